// File: doc/BRIEF.md
# External Interrupt Request Sampler

This block turns a set of active-low external interrupt pins into request flags for an interrupt controller. Each pin is first brought into the clock domain by a two-stage synchroniser. It is then sampled only on a machine-cycle tick, which an internal counter raises once every `CYCLE_LEN` clocks (12 by default). A separate trigger-mode input for each channel selects how the flag is raised. In level mode the flag follows the sampled pin. In edge mode the flag is set by a high sample followed by a low sample.

The controller pulses a vector-acknowledge input when it dispatches to a channel. That pulse clears the flag only in edge mode. In level mode the acknowledge is ignored, and the flag stays set for as long as the pin is sampled low. Software may also write the flag directly. The new value takes effect on the next clock, except that a hardware set in the same cycle takes priority.

Top module: `extint_sampler`

## Requirements
- R1: The output `mc_tick` is high for one clock in every `CYCLE_LEN` clocks (12 by default).
- R2: In level mode (`trig_edge`=0), a tick that samples the synchronised pin low sets `req`, and a tick that samples it high clears `req`. Between ticks, `req` holds its value.
- R3: In level mode, `vec_ack` has no effect on `req`. If software clears the flag while the pin is still low, the next tick sets it again.
- R4: In edge mode (`trig_edge`=1), `req` is set by a tick whose sample is low when the previous tick's sample was high. A pin that stays low after the flag is cleared does not set it again.
- R5: In edge mode, `vec_ack` high clears `req` on the next clock.
- R6: In edge mode, a low pulse that starts after one tick and ends before the next is not captured.
- R7: In edge mode, a pin held low through reset causes no request. The stored previous sample resets to the low state.
- R8: `sw_we` high writes `sw_wdata` into `req` on the next clock.
- R9: A hardware set and a software write of 0 in the same cycle leave `req` at 1.
- R10: During reset, `req` is 0 on every channel.
- R11: Each channel's pin, mode, acknowledge and write inputs affect only that channel's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside the block |
| pin_n | input | NCH | Active-low external interrupt pins, asynchronous |
| trig_edge | input | NCH | Trigger mode for each channel: 1 = falling edge, 0 = low level |
| vec_ack | input | NCH | Controller has vectored to this channel |
| sw_we | input | NCH | Software write strobe for each flag |
| sw_wdata | input | NCH | Value written by software |
| req | output | NCH | Interrupt request flags |
| mc_tick | output | 1 | Machine-cycle sample strobe |

## Verification
A vector table on channel 0 steps through several pin and mode sequences:
- a falling edge followed by an acknowledge, which separates edge capture from the clear-on-vector rule;
- a pin held low after the clear, which shows whether the block wrongly re-triggers in edge mode;
- level-mode low and high phases with an acknowledge applied, which show the flag tracking the pin and the acknowledge being ignored.

Channel 1 is held idle during the table to expose crosstalk between channels. Directed tests then cover:
- a low pulse that falls entirely between two ticks;
- a pin held low through reset;
- a software clear placed on the same clock as an edge-mode set;
- a software clear in level mode while the pin stays low.

// File: rtl/extint_pkg.sv
package extint_pkg;

  // Trigger modes, encoded as the per-channel mode input.
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_mode_e;

  // Width of a counter that must reach n-1.
  function automatic int cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/extint_rst_sync.sv
module extint_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;

endmodule

// File: rtl/extint_tick_gen.sv
module extint_tick_gen #(
  parameter int CYCLE_LEN = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int CW = extint_pkg::cnt_width(CYCLE_LEN);
  localparam logic [CW-1:0] LAST = CW'(CYCLE_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    if (at_last) cnt_d = '0;
    else         cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = at_last;

endmodule

// File: rtl/extint_pin_sync.sv
module extint_pin_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_sync
);

  // Idle (high) is the reset value, so reset itself creates no transition.
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= pin_async;
      sync_q <= meta_q;
    end
  end

  assign pin_sync = sync_q;

endmodule

// File: rtl/extint_chan.sv
module extint_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_s,
  input  logic mode,
  input  logic ack,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);

  import extint_pkg::*;

  logic samp_q;
  logic samp_d;
  logic flag_q;
  logic flag_d;
  logic hw_set;
  logic lvl_clr;
  logic edg_clr;
  logic is_edge;

  assign is_edge = (trig_mode_e'(mode) == TRIG_EDGE);

  // A new sample is taken only on the tick; samp_q holds the previous one.
  always_comb begin
    if (tick) samp_d = pin_s;
    else      samp_d = samp_q;
  end

  // Set: edge mode needs high then low; level mode needs any low sample.
  assign hw_set  = tick && !pin_s && (is_edge ? samp_q : 1'b1);
  assign lvl_clr = tick && pin_s && !is_edge;
  assign edg_clr = ack && is_edge;

  // Priority, highest first: hw set, sw write, vector clear, level clear.
  always_comb begin
    if (hw_set)       flag_d = 1'b1;
    else if (wr_en)   flag_d = wr_val;
    else if (edg_clr) flag_d = 1'b0;
    else if (lvl_clr) flag_d = 1'b0;
    else              flag_d = flag_q;
  end

  // Previous sample resets low so a pin held low through reset gives no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      samp_q <= samp_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/extint_sampler.sv
module extint_sampler #(
  parameter int NCH       = 2,
  parameter int CYCLE_LEN = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] pin_n,
  input  logic [NCH-1:0] trig_edge,
  input  logic [NCH-1:0] vec_ack,
  input  logic [NCH-1:0] sw_we,
  input  logic [NCH-1:0] sw_wdata,
  output logic [NCH-1:0] req,
  output logic           mc_tick
);

  logic rst_n_int;
  logic tick;

  extint_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  extint_tick_gen #(.CYCLE_LEN(CYCLE_LEN)) u_tick (
    .clk   (clk),
    .rst_n (rst_n_int),
    .tick  (tick)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic pin_s;

    extint_pin_sync u_sync (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .pin_async (pin_n[g]),
      .pin_sync  (pin_s)
    );

    extint_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .tick   (tick),
      .pin_s  (pin_s),
      .mode   (trig_edge[g]),
      .ack    (vec_ack[g]),
      .wr_en  (sw_we[g]),
      .wr_val (sw_wdata[g]),
      .flag   (req[g])
    );
  end

  assign mc_tick = tick;

endmodule

// File: rtl/extint_sampler_chk.sv
module extint_sampler_chk #(
  parameter int NCH       = 2,
  parameter int CYCLE_LEN = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] trig_edge,
  input logic [NCH-1:0] vec_ack,
  input logic [NCH-1:0] sw_we,
  input logic [NCH-1:0] req,
  input logic           mc_tick
);

  // Gap counter: the tick period is checked with a counter, not a long $past.
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (mc_tick) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q <= gap_q + 16'd1;
    end
  end

  p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_tick && seen_q) |-> (gap_q == 16'(CYCLE_LEN - 1)));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    p_edge_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_edge[g] && vec_ack[g] && !mc_tick && !sw_we[g]) |=> !req[g]);

    p_level_ack_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_edge[g] && vec_ack[g] && !mc_tick && !sw_we[g] && req[g]) |=> req[g]);

    p_rise_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req[g]) |-> $past(mc_tick || sw_we[g]));

    p_fall_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req[g]) |-> $past(mc_tick || sw_we[g] || (vec_ack[g] && trig_edge[g])));
  end

endmodule

bind extint_sampler extint_sampler_chk #(.NCH(NCH), .CYCLE_LEN(CYCLE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_edge (trig_edge),
  .vec_ack   (vec_ack),
  .sw_we     (sw_we),
  .req       (req),
  .mc_tick   (mc_tick)
);

// File: tb/tb_extint_sampler.sv
module tb_extint_sampler;

  localparam int NCH  = 2;
  localparam int CLEN = 12;
  localparam int SETTLE = 2 * CLEN + 2;

  logic           clk;
  logic           rst_n;
  logic [NCH-1:0] pin_n;
  logic [NCH-1:0] trig_edge;
  logic [NCH-1:0] vec_ack;
  logic [NCH-1:0] sw_we;
  logic [NCH-1:0] sw_wdata;
  logic [NCH-1:0] req;
  logic           mc_tick;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  extint_sampler #(.NCH(NCH), .CYCLE_LEN(CLEN)) dut (
    .clk (clk), .rst_n (rst_n), .pin_n (pin_n), .trig_edge (trig_edge),
    .vec_ack (vec_ack), .sw_we (sw_we), .sw_wdata (sw_wdata),
    .req (req), .mc_tick (mc_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Vector: {mode(1=edge), pin_n, ack pulse, expected req[0]}
  localparam int NV = 12;
  localparam logic [3:0] VEC [NV] = '{
    4'b1_1_0_0,  // R4 idle high
    4'b1_0_0_1,  // R4 falling edge captured
    4'b1_0_1_0,  // R5 ack clears in edge mode
    4'b1_0_0_0,  // R4 held low: no re-trigger
    4'b1_1_0_0,  // R4 back high
    4'b1_0_0_1,  // R4 second edge
    4'b0_0_1_1,  // R3 level mode, ack ignored
    4'b0_1_0_0,  // R2 level clears on high sample
    4'b0_0_0_1,  // R2 level set on low sample
    4'b0_1_0_0,  // R2 level clears again
    4'b1_1_0_0,  // R4 edge mode idle
    4'b1_0_0_1   // R4 edge captured
  };

  task automatic check(input string req_id, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req_id, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  // Return at the negedge just after a tick edge (counter at 0).
  task automatic align();
    do @(negedge clk); while (!mc_tick);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pin_n = '1; trig_edge = '1; vec_ack = '0; sw_we = '0; sw_wdata = '0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 req0 in reset", req[0], 1'b0);
    check("R10 req1 in reset", req[1], 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: tick period
    begin
      int gap;
      align();
      gap = 1;
      while (!mc_tick) begin @(negedge clk); gap++; end
      checks++;
      if (gap != CLEN) begin
        errors++;
        $display("FAIL R1: actual %0d expected %0d", gap, CLEN);
      end
    end

    // Table walk on channel 0; channel 1 idle high in edge mode (R11)
    for (int i = 0; i < NV; i++) begin
      trig_edge[0] = VEC[i][3];
      pin_n[0]     = VEC[i][2];
      if (VEC[i][1]) begin
        vec_ack[0] = 1'b1;
        @(negedge clk);
        vec_ack[0] = 1'b0;
      end
      repeat (SETTLE) @(negedge clk);
      check($sformatf("R2/R3/R4/R5 vec %0d", i), req[0], VEC[i][0]);
      check("R11 channel 1 untouched", req[1], 1'b0);
    end

    // R6: short pulse between ticks is missed
    trig_edge = '1; pin_n = '1;
    do_reset();
    repeat (SETTLE) @(negedge clk);
    align();
    pin_n[0] = 1'b0;
    repeat (3) @(negedge clk);
    pin_n[0] = 1'b1;
    repeat (SETTLE) @(negedge clk);
    check("R6 short pulse missed", req[0], 1'b0);

    // R7: pin low through reset (edge ch0), level ch1 asserts
    pin_n = 2'b00; trig_edge = 2'b01;
    do_reset();
    repeat (SETTLE) @(negedge clk);
    check("R7 no false edge", req[0], 1'b0);
    check("R11 level channel asserts", req[1], 1'b1);

    // R3: level software clear with pin still low re-triggers
    align();
    sw_we[1] = 1'b1; sw_wdata[1] = 1'b0;
    @(negedge clk);
    sw_we[1] = 1'b0;
    check("R3 sw clear takes effect", req[1], 1'b0);
    repeat (SETTLE) @(negedge clk);
    check("R3 level re-trigger", req[1], 1'b1);

    // R8: software write set/clear in edge mode, pin high
    pin_n = '1; trig_edge = '1;
    do_reset();
    repeat (SETTLE) @(negedge clk);
    align();
    sw_we[0] = 1'b1; sw_wdata[0] = 1'b1;
    @(negedge clk);
    sw_we[0] = 1'b0;
    check("R8 sw write 1", req[0], 1'b1);
    sw_we[0] = 1'b1; sw_wdata[0] = 1'b0;
    @(negedge clk);
    sw_we[0] = 1'b0;
    check("R8 sw write 0", req[0], 1'b0);

    // R9: hardware set beats software clear in the same cycle
    align();
    pin_n[0] = 1'b0;
    do @(negedge clk); while (!mc_tick);
    sw_we[0] = 1'b1; sw_wdata[0] = 1'b0;
    @(negedge clk);
    sw_we[0] = 1'b0;
    check("R9 set wins over sw clear", req[0], 1'b1);

    finish_run();
  end

endmodule